// File: doc/BRIEF.md
# Reduced-Clock Exit Gating Unit

This unit owns the clock divider setting of a processor core that can slow itself down to save power. Software requests a divider mode by writing a two-bit code: full speed or one of two reduced-speed modes. The unit applies every mode change only on an instruction-cycle boundary, which the core marks with a one-cycle strobe. A request to enter a reduced mode is deferred while either serial port is receiving or shifting out a character, because changing the divider mid-character would corrupt it. A held-entry flag shows the deferral.

While a reduced mode is active, the unit watches for wake events: tagged interrupt requests, each marked high or low priority, and serial receive-start and transmit-start events, which rank as low priority. A wake event that the current interrupt service level does not lock out returns the divider to full speed at the next boundary, and a one-cycle pulse reports the exit. Only the divider setting is restored. Nothing else, including whichever oscillator is driving the core, is touched.

A status byte shows the per-port serial activity and the two in-service levels, so software can check that it is safe to enter a reduced mode.

Top module: `clkdiv_wake_gate`

## Requirements
- R1: After reset the mode is full speed (code 0), `divRatio` equals `DIV_FULL`, `exitPulse` and `entryHeld` are 0, and `statusReg` is 0 while both in-service inputs are low.
- R2: `statusReg` bit 0 is receive activity on port 0 and bit 1 is transmit activity on port 0. Bits 2 and 3 are the same two flags for port 1. Bit 5 follows `loInSvc`, bit 6 follows `hiInSvc`, and bits 4 and 7 read 0. An activity flag is set by its start event and cleared by its done event; when both arrive in the same cycle, the start wins.
- R3: Mode code 0 is full speed (`DIV_FULL`), code 1 is reduced mode A (`DIV_SLOW1`), code 2 is reduced mode B (`DIV_SLOW2`), and code 3 is ignored. A write takes effect at the first `cycleEdge` cycle strictly after the write cycle. `curMode` and `divRatio` never change in any other cycle.
- R4: A reduced-mode request is not applied at a boundary while any activity flag is set; `entryHeld` reads 1 meanwhile. The request is applied at the first boundary at which all four activity flags are clear.
- R5: In a reduced mode, an allowed wake event sets the mode to full speed at the first `cycleEdge` cycle, counting the event's own cycle. `exitPulse` is 1 for exactly the cycle after that edge.
- R6: While `hiInSvc` is 1, no wake event of either priority causes an exit.
- R7: While `loInSvc` is 1 and `hiInSvc` is 0, a high-priority interrupt (matching `irqHigh` bit 1) causes an exit, and a low-priority interrupt does not.
- R8: Serial receive-start and transmit-start events on either port are low-priority wake events.
- R9: An allowed wake event discards a reduced-mode write made in the same cycle, and it cancels a reduced-mode request that is still pending.
- R10: A full-speed write is applied at the next boundary even while activity flags are set, and it raises no `exitPulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cycleEdge | input | 1 | One-cycle strobe marking an instruction-cycle boundary |
| irqReq | input | NUM_IRQ | Interrupt request lines |
| irqHigh | input | NUM_IRQ | Priority tag per request line, 1 = high |
| hiInSvc | input | 1 | A high-priority routine is in service |
| loInSvc | input | 1 | A low-priority routine is in service |
| rxStart | input | 2 | Receive-start event per serial port |
| rxDone | input | 2 | Receive-complete event per serial port |
| txStart | input | 2 | Transmit-start event per serial port |
| txDone | input | 2 | Transmit-complete event per serial port |
| divWrEn | input | 1 | Divider mode write strobe |
| divWrData | input | 2 | Mode code to write |
| divRatio | output | DIV_W | Active clock divider value |
| curMode | output | 2 | Active mode code |
| statusReg | output | 8 | Activity and in-service status byte |
| entryHeld | output | 1 | A reduced-mode request waits for serial activity to end |
| exitPulse | output | 1 | One-cycle report of a wake exit |

## Verification
A wake event and a divider write can land in the same cycle, and a pending request can reach its boundary in the same cycle that a wake is applied. The bench provokes the first case by writing reduced mode B together with a low-priority request while the unit is in mode A. It then checks that the next boundary brings full speed with a pulse, and that a further boundary leaves the mode at full speed. The second case is provoked by cancelling a request held for serial activity with a wake event; the bench checks that `entryHeld` drops and that the request never takes effect.

// File: rtl/wake_pkg.sv
`timescale 1ns/1ps
package wake_pkg;
  localparam int SER_PORTS = 2;

  typedef enum logic [1:0] {
    MODE_FULL  = 2'd0,
    MODE_SLOW1 = 2'd1,
    MODE_SLOW2 = 2'd2,
    MODE_RSVD  = 2'd3
  } divMode_e;

  typedef struct packed {
    logic loadReq;   // capture a new mode request
    logic applyReq;  // move the pending request into the active mode
    logic dropReq;   // discard the pending request
    logic exitNow;   // return to full speed this boundary
  } ctrlStb_t;
endpackage

// File: rtl/wake_ctrl.sv
`timescale 1ns/1ps
module wake_ctrl
  import wake_pkg::*;
#(
  parameter int NUM_IRQ = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cycleEdge,
  input  logic [NUM_IRQ-1:0]   irqReq,
  input  logic [NUM_IRQ-1:0]   irqHigh,
  input  logic [SER_PORTS-1:0] rxStart,
  input  logic [SER_PORTS-1:0] txStart,
  input  logic                 hiInSvc,
  input  logic                 loInSvc,
  input  logic                 divWrEn,
  input  divMode_e             wrMode,
  input  divMode_e             curMode,
  input  divMode_e             pendMode,
  input  logic                 pendValid,
  input  logic                 anyAct,
  output ctrlStb_t             stb
);
  logic hiWake, loWake, wakeHit;
  logic inReduced, wrLegal, wrReduced, pendReduced;
  logic wakeHold;

  // serial start events rank with low-priority requests (R8)
  assign hiWake = |(irqReq & irqHigh);
  assign loWake = (|(irqReq & ~irqHigh)) | (|rxStart) | (|txStart);

  // service-level lockout: high in service blocks all (R6), low blocks low (R7)
  assign wakeHit = (hiWake & ~hiInSvc) | (loWake & ~hiInSvc & ~loInSvc);

  assign inReduced   = (curMode == MODE_SLOW1) || (curMode == MODE_SLOW2);
  assign wrLegal     = (wrMode != MODE_RSVD);
  assign wrReduced   = wrLegal && (wrMode != MODE_FULL);
  assign pendReduced = pendValid && (pendMode != MODE_FULL);

  always_comb begin
    stb.exitNow  = cycleEdge & inReduced & (wakeHold | wakeHit);
    stb.dropReq  = stb.exitNow | (wakeHit & pendReduced);
    stb.loadReq  = divWrEn & wrLegal & ~(wakeHit & wrReduced);
    stb.applyReq = cycleEdge & pendValid & ~stb.dropReq &
                   ((pendMode == MODE_FULL) | ~anyAct);
  end

  // remembers an allowed wake that arrived between boundaries
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      wakeHold <= 1'b0;
    else if (stb.exitNow || stb.applyReq)
      wakeHold <= 1'b0;
    else if (wakeHit && inReduced)
      wakeHold <= 1'b1;
  end
endmodule

// File: rtl/wake_dpath.sv
`timescale 1ns/1ps
module wake_dpath
  import wake_pkg::*;
#(
  parameter int DIV_W     = 12,
  parameter int DIV_FULL  = 4,
  parameter int DIV_SLOW1 = 64,
  parameter int DIV_SLOW2 = 1024
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStb_t             stb,
  input  divMode_e             wrMode,
  input  logic [SER_PORTS-1:0] rxStart,
  input  logic [SER_PORTS-1:0] rxDone,
  input  logic [SER_PORTS-1:0] txStart,
  input  logic [SER_PORTS-1:0] txDone,
  input  logic                 hiInSvc,
  input  logic                 loInSvc,
  output divMode_e             curMode,
  output divMode_e             pendMode,
  output logic                 pendValid,
  output logic                 anyAct,
  output logic                 entryHeld,
  output logic                 exitPulse,
  output logic [DIV_W-1:0]     divRatio,
  output logic [7:0]           statusReg
);
  localparam int ACT_W  = 2 * SER_PORTS;
  localparam int LO_BIT = 5;
  localparam int HI_BIT = 6;

  logic [ACT_W-1:0] actVec;

  // per-port activity flags: even bit receive, odd bit transmit; start wins
  for (genvar p = 0; p < SER_PORTS; p++) begin : g_port
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        actVec[2*p]   <= 1'b0;
        actVec[2*p+1] <= 1'b0;
      end else begin
        if (rxStart[p])     actVec[2*p] <= 1'b1;
        else if (rxDone[p]) actVec[2*p] <= 1'b0;
        if (txStart[p])     actVec[2*p+1] <= 1'b1;
        else if (txDone[p]) actVec[2*p+1] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curMode   <= MODE_FULL;
      pendMode  <= MODE_FULL;
      pendValid <= 1'b0;
      exitPulse <= 1'b0;
    end else begin
      exitPulse <= stb.exitNow;
      if (stb.exitNow)
        curMode <= MODE_FULL;
      else if (stb.applyReq)
        curMode <= pendMode;
      if (stb.dropReq)
        pendValid <= 1'b0;
      else if (stb.loadReq) begin
        pendValid <= 1'b1;
        pendMode  <= wrMode;
      end else if (stb.applyReq)
        pendValid <= 1'b0;
    end
  end

  always_comb begin
    case (curMode)
      MODE_SLOW1: divRatio = DIV_W'(DIV_SLOW1);
      MODE_SLOW2: divRatio = DIV_W'(DIV_SLOW2);
      default:    divRatio = DIV_W'(DIV_FULL);
    endcase
  end

  always_comb begin
    statusReg            = '0;
    statusReg[ACT_W-1:0] = actVec;
    statusReg[LO_BIT]    = loInSvc;
    statusReg[HI_BIT]    = hiInSvc;
  end

  assign anyAct    = |actVec;
  assign entryHeld = pendValid && (pendMode != MODE_FULL) && anyAct;
endmodule

// File: rtl/clkdiv_wake_gate.sv
`timescale 1ns/1ps
module clkdiv_wake_gate
  import wake_pkg::*;
#(
  parameter int NUM_IRQ   = 2,
  parameter int DIV_W     = 12,
  parameter int DIV_FULL  = 4,
  parameter int DIV_SLOW1 = 64,
  parameter int DIV_SLOW2 = 1024
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cycleEdge,
  input  logic [NUM_IRQ-1:0] irqReq,
  input  logic [NUM_IRQ-1:0] irqHigh,
  input  logic               hiInSvc,
  input  logic               loInSvc,
  input  logic [1:0]         rxStart,
  input  logic [1:0]         rxDone,
  input  logic [1:0]         txStart,
  input  logic [1:0]         txDone,
  input  logic               divWrEn,
  input  logic [1:0]         divWrData,
  output logic [DIV_W-1:0]   divRatio,
  output logic [1:0]         curMode,
  output logic [7:0]         statusReg,
  output logic               entryHeld,
  output logic               exitPulse
);
  ctrlStb_t stb;
  divMode_e wrMode, modeNow, pendMode;
  logic     pendValid, anyAct;

  assign wrMode  = divMode_e'(divWrData);
  assign curMode = modeNow;

  wake_ctrl #(.NUM_IRQ(NUM_IRQ)) u_ctrl (
    .clk(clk), .rstN(rstN), .cycleEdge(cycleEdge),
    .irqReq(irqReq), .irqHigh(irqHigh),
    .rxStart(rxStart), .txStart(txStart),
    .hiInSvc(hiInSvc), .loInSvc(loInSvc),
    .divWrEn(divWrEn), .wrMode(wrMode),
    .curMode(modeNow), .pendMode(pendMode),
    .pendValid(pendValid), .anyAct(anyAct),
    .stb(stb)
  );

  wake_dpath #(
    .DIV_W(DIV_W), .DIV_FULL(DIV_FULL),
    .DIV_SLOW1(DIV_SLOW1), .DIV_SLOW2(DIV_SLOW2)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .wrMode(wrMode),
    .rxStart(rxStart), .rxDone(rxDone),
    .txStart(txStart), .txDone(txDone),
    .hiInSvc(hiInSvc), .loInSvc(loInSvc),
    .curMode(modeNow), .pendMode(pendMode),
    .pendValid(pendValid), .anyAct(anyAct),
    .entryHeld(entryHeld), .exitPulse(exitPulse),
    .divRatio(divRatio), .statusReg(statusReg)
  );
endmodule

// File: rtl/wake_gate_chk.sv
`timescale 1ns/1ps
module wake_gate_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cycleEdge,
  input logic [1:0] curMode,
  input logic [7:0] statusReg,
  input logic       exitPulse
);
  // R5: a wake exit lands on a boundary and leaves full speed behind
  assert_exit_on_edge_R5: assert property (@(posedge clk) disable iff (!rstN)
    exitPulse |-> (curMode == 2'd0) && $past(cycleEdge));

  // R5: an exit only happens out of a reduced mode
  assert_exit_from_reduced_R5: assert property (@(posedge clk) disable iff (!rstN)
    exitPulse |-> ($past(curMode) != 2'd0));

  // R5: the exit report lasts a single cycle
  assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    exitPulse |=> !exitPulse);

  // R3: the active mode moves only on an instruction-cycle boundary
  assert_mode_on_edge_R3: assert property (@(posedge clk) disable iff (!rstN)
    (curMode != $past(curMode)) |-> $past(cycleEdge));

  // R4: entry into a reduced mode never happens while serial activity is flagged
  assert_no_busy_entry_R4: assert property (@(posedge clk) disable iff (!rstN)
    (($past(curMode) == 2'd0) && (curMode != 2'd0)) |-> ($past(statusReg[3:0]) == 4'd0));
endmodule

bind clkdiv_wake_gate wake_gate_chk u_chk (
  .clk(clk), .rstN(rstN), .cycleEdge(cycleEdge),
  .curMode(curMode), .statusReg(statusReg), .exitPulse(exitPulse)
);

// File: tb/clkdiv_wake_gate_tb.sv
`timescale 1ns/1ps
module clkdiv_wake_gate_tb;
  localparam int DIV_W = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cycleEdge = 1'b0;
  logic [1:0] irqReq = '0, irqHigh = '0;
  logic hiInSvc = 1'b0, loInSvc = 1'b0;
  logic [1:0] rxStart = '0, rxDone = '0, txStart = '0, txDone = '0;
  logic divWrEn = 1'b0;
  logic [1:0] divWrData = '0;
  logic [DIV_W-1:0] divRatio;
  logic [1:0] curMode;
  logic [7:0] statusReg;
  logic entryHeld, exitPulse;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  clkdiv_wake_gate u_dut (
    .clk(clk), .rstN(rstN), .cycleEdge(cycleEdge),
    .irqReq(irqReq), .irqHigh(irqHigh),
    .hiInSvc(hiInSvc), .loInSvc(loInSvc),
    .rxStart(rxStart), .rxDone(rxDone),
    .txStart(txStart), .txDone(txDone),
    .divWrEn(divWrEn), .divWrData(divWrData),
    .divRatio(divRatio), .curMode(curMode), .statusReg(statusReg),
    .entryHeld(entryHeld), .exitPulse(exitPulse)
  );

  // {irqReq[1:0], irqHigh[1:0], rx0 start, tx1 start, hiInSvc, loInSvc, expect exit}
  localparam logic [8:0] VEC [12] = '{
    9'b01_00_0_0_0_0_1,  // low irq, nothing in service
    9'b10_10_0_0_0_0_1,  // high irq, nothing in service
    9'b01_00_0_0_0_1_0,  // low irq locked by low service
    9'b10_10_0_0_0_1_1,  // high irq passes low service
    9'b10_10_0_0_1_0_0,  // high irq locked by high service
    9'b01_00_0_0_1_0_0,  // low irq locked by high service
    9'b00_00_1_0_0_0_1,  // serial receive start wakes
    9'b00_00_0_1_0_1_0,  // serial transmit start locked by low service
    9'b00_00_0_0_0_0_0,  // no event
    9'b11_10_0_0_0_1_1,  // mixed, high one passes
    9'b00_00_0_1_1_1_0,  // serial locked by both levels
    9'b10_10_1_0_1_0_0   // everything locked by high service
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic writeMode(input logic [1:0] m);
    divWrEn = 1'b1; divWrData = m;
    step();
    divWrEn = 1'b0;
  endtask

  task automatic edgeCyc();
    cycleEdge = 1'b1;
    step();
    cycleEdge = 1'b0;
  endtask

  task automatic clearAct();
    rxDone = 2'b11; txDone = 2'b11;
    step();
    rxDone = '0; txDone = '0;
  endtask

  task automatic forceFull();
    writeMode(2'd0);
    edgeCyc();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 mode", curMode, 0);
    chk("R1 divRatio", divRatio, 4);
    chk("R1 status", statusReg, 0);
    chk("R1 entryHeld", entryHeld, 0);
    chk("R1 exitPulse", exitPulse, 0);

    // vector table: enter mode A, present a wake candidate on a boundary
    for (int i = 0; i < 12; i++) begin
      logic [8:0] v;
      v = VEC[i];
      clearAct();
      forceFull();
      writeMode(2'd1);
      edgeCyc();
      chk("R3 enter slow1", curMode, 1);
      irqReq = v[8:7]; irqHigh = v[6:5];
      rxStart[0] = v[4]; txStart[1] = v[3];
      hiInSvc = v[2]; loInSvc = v[1];
      cycleEdge = 1'b1;
      step();
      irqReq = '0; irqHigh = '0; rxStart = '0; txStart = '0; cycleEdge = 1'b0;
      chk("R5 R6 R7 R8 mode", curMode, v[0] ? 0 : 1);
      chk("R5 R6 R7 R8 pulse", exitPulse, v[0]);
      chk("R3 divRatio", divRatio, v[0] ? 4 : 64);
      chk("R2 hi bit", statusReg[6], v[2]);
      chk("R2 lo bit", statusReg[5], v[1]);
      step();
      chk("R5 pulse one cycle", exitPulse, 0);
      hiInSvc = 1'b0; loInSvc = 1'b0;
    end
    clearAct();
    forceFull();

    // R3: write in a boundary cycle waits for the next boundary
    divWrEn = 1'b1; divWrData = 2'd2; cycleEdge = 1'b1;
    step();
    divWrEn = 1'b0; cycleEdge = 1'b0;
    chk("R3 not same cycle", curMode, 0);
    step();
    chk("R3 no boundary", curMode, 0);
    edgeCyc();
    chk("R3 mode B", curMode, 2);
    chk("R3 divRatio B", divRatio, 1024);
    writeMode(2'd3);
    edgeCyc();
    chk("R3 code 3 ignored", curMode, 2);
    forceFull();

    // R2: start beats done in the same cycle; field positions
    rxStart[0] = 1'b1; rxDone[0] = 1'b1; txStart[1] = 1'b1;
    step();
    rxStart = '0; rxDone = '0; txStart = '0;
    chk("R2 status set", statusReg, 8'h09);
    txDone[1] = 1'b1;
    step();
    txDone = '0;
    chk("R2 status clear", statusReg, 8'h01);

    // R4: entry held while port 0 receive is active
    writeMode(2'd2);
    chk("R4 held flag", entryHeld, 1);
    edgeCyc();
    chk("R4 held mode", curMode, 0);
    rxDone[0] = 1'b1;
    step();
    rxDone = '0;
    chk("R4 flag drops", entryHeld, 0);
    chk("R4 no early entry", curMode, 0);
    edgeCyc();
    chk("R4 entry after idle", curMode, 2);
    chk("R4 no pulse", exitPulse, 0);

    // R10: full-speed write while busy, no pulse
    loInSvc = 1'b1;
    txStart[0] = 1'b1;
    step();
    txStart = '0;
    writeMode(2'd0);
    edgeCyc();
    chk("R10 full while busy", curMode, 0);
    chk("R10 no pulse", exitPulse, 0);
    loInSvc = 1'b0;
    clearAct();

    // R5: wake between boundaries exits at the next boundary
    writeMode(2'd1);
    edgeCyc();
    irqReq = 2'b01;
    step();
    irqReq = '0;
    chk("R5 wait for boundary", curMode, 1);
    chk("R5 no pulse yet", exitPulse, 0);
    step();
    edgeCyc();
    chk("R5 deferred exit", curMode, 0);
    chk("R5 deferred pulse", exitPulse, 1);

    // R9: wake in the same cycle as a reduced write discards the write
    writeMode(2'd1);
    edgeCyc();
    irqReq = 2'b01; divWrEn = 1'b1; divWrData = 2'd2;
    step();
    irqReq = '0; divWrEn = 1'b0;
    edgeCyc();
    chk("R9 exit wins", curMode, 0);
    chk("R9 exit pulse", exitPulse, 1);
    edgeCyc();
    chk("R9 write discarded", curMode, 0);

    // R9: wake cancels a held entry
    rxStart[0] = 1'b1;
    step();
    rxStart = '0;
    writeMode(2'd1);
    chk("R9 held before", entryHeld, 1);
    irqReq = 2'b10; irqHigh = 2'b10;
    step();
    irqReq = '0; irqHigh = '0;
    chk("R9 held cancelled", entryHeld, 0);
    clearAct();
    edgeCyc();
    chk("R9 cancelled never applies", curMode, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule